// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block tracks micro-operations between their allocation in program order and their retirement. Each micro-op takes one slot of a circular buffer. It is tagged with the slot index, and that index travels with it through the execution units. When a result comes back, the completion port marks the slot as executed by its tag, in whatever order results arrive. A branch slot waits on the branch-resolution port, which reports whether the branch was predicted correctly. Only the oldest slot can leave. It leaves once it has executed, so nothing can retire past a branch that is still unresolved.

The block presents the oldest executed micro-op on the retire output. That output carries the micro-op code, its memory address, its renamed destination register and its tag. When the retiring slot is a mispredicted branch, the block raises a flush indication in the same cycle. It then frees every younger slot, leaving the buffer empty, with allocation resuming at the slot just after the branch.

Top module: `uop_reorder_buf`

## Requirements
- R1: After a synchronous active-high reset, occupancy is 0, alloc_ready is 1, alloc_tag is 0 and ret_valid is 0.
- R2: A micro-op is accepted on a cycle where alloc_valid and alloc_ready are both 1. It receives the tag shown on alloc_tag in that cycle. Tags are handed out in increasing order, wrapping from DEPTH-1 to 0.
- R3: alloc_ready is 0 while occupancy equals DEPTH. An alloc_valid in that state is ignored, and occupancy stays at DEPTH.
- R4: Retirement follows allocation order. ret_tag, ret_uop, ret_addr and ret_alias show the oldest slot's stored values, whatever order the completions arrived in.
- R5: ret_valid is 1 exactly when the oldest slot has executed. An executed younger slot never retires ahead of an unexecuted older one.
- R6: A slot allocated with alloc_is_branch=1 becomes executed only through br_valid with its tag. A completion write (wb_valid) to a branch slot is ignored.
- R7: A branch resolved with br_mispredict=0 retires with ret_flush=0, and the younger slots remain and retire afterwards.
- R8: A branch resolved with br_mispredict=1 retires with ret_flush=1, and alloc_ready is 0 in that cycle. On the next cycle occupancy is 0 and alloc_tag is the branch tag plus one, modulo DEPTH.
- R9: A completion write to a free slot, or to a slot freed by a flush, has no effect. A micro-op later allocated into that slot still waits for its own completion.
- R10: At most one slot retires per cycle. Occupancy rises by one per accepted allocation, falls by one per retirement, and is unchanged when both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | A new micro-op is offered |
| alloc_is_branch | input | 1 | The offered micro-op is a branch |
| alloc_uop | input | UOP_W | Micro-op code |
| alloc_addr | input | ADDR_W | Memory address of the micro-op |
| alloc_alias | input | AREG_W | Renamed destination register |
| alloc_ready | output | 1 | A micro-op can be accepted this cycle |
| alloc_tag | output | IDX_W | Tag given to an accepted micro-op |
| wb_valid | input | 1 | Completion write-back strobe |
| wb_tag | input | IDX_W | Tag of the completed micro-op |
| br_valid | input | 1 | Branch resolution strobe |
| br_tag | input | IDX_W | Tag of the resolved branch |
| br_mispredict | input | 1 | The resolved branch was mispredicted |
| ret_valid | output | 1 | The oldest micro-op retires this cycle |
| ret_flush | output | 1 | The retiring micro-op is a mispredicted branch |
| ret_tag | output | IDX_W | Tag of the retiring micro-op |
| ret_uop | output | UOP_W | Micro-op code of the retiring slot |
| ret_addr | output | ADDR_W | Memory address of the retiring slot |
| ret_alias | output | AREG_W | Destination register of the retiring slot |
| occupancy | output | CNT_W | Number of slots in use |

## Verification
A corrupted slot state shows up on ret_valid no later than the cycle in which that slot becomes the oldest. A missed completion makes retirement stall. A spurious one lets a micro-op retire before its result exists. A pointer or count error appears at once on alloc_tag or occupancy, which the bench compares with its own queue model on every cycle. A flush that leaves stale slots behind shows up only after new micro-ops reuse those tags. For that reason the bench completes flushed tags and reallocates them under both directed and random stimulus.

// File: rtl/urob_pkg.sv
package urob_pkg;
  // Slot life-cycle encoding
  typedef enum logic [1:0] {
    ENT_FREE   = 2'b00,
    ENT_WAIT   = 2'b01,
    ENT_DONE   = 2'b10,
    ENT_BRWAIT = 2'b11
  } ent_state_e;
endpackage

// File: rtl/urob_ptrs.sv
module urob_ptrs #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush_fire,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic up, input logic dn);
    case ({up, dn})
      2'b10:   return c + 1'b1;
      2'b01:   return c - 1'b1;
      default: return c;
    endcase
  endfunction

  assign full = (count == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush_fire) begin
      head  <= wrap_inc(head);
      tail  <= wrap_inc(head);
      count <= '0;
    end else begin
      if (alloc_fire)  tail <= wrap_inc(tail);
      if (retire_fire) head <= wrap_inc(head);
      count <= next_count(count, alloc_fire, retire_fire);
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |-> !full);
  p_alloc_step_r2: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && !flush_fire) |=> tail == wrap_inc($past(tail)));
  p_head_step_r4: assert property (@(posedge clk) disable iff (rst)
    (retire_fire && !flush_fire) |=> head == wrap_inc($past(head)));
  p_both_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (alloc_fire && retire_fire && !flush_fire) |=> $stable(count));
  p_flush_empty_r8: assert property (@(posedge clk) disable iff (rst)
    flush_fire |=> (count == '0) && (head == tail));
endmodule

// File: rtl/urob_state.sv
module urob_state
  import urob_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  alloc_fire,
  input  logic                  alloc_is_branch,
  input  logic [IDX_W-1:0]      tail,
  input  logic [IDX_W-1:0]      head,
  input  logic                  wb_valid,
  input  logic [IDX_W-1:0]      wb_tag,
  input  logic                  br_valid,
  input  logic [IDX_W-1:0]      br_tag,
  input  logic                  br_mispredict,
  input  logic                  retire_fire,
  input  logic                  flush_fire,
  output logic [DEPTH-1:0][1:0] st_vec,
  output logic [DEPTH-1:0]      mp_vec,
  output logic                  wb_hit,
  output logic                  br_hit
);
  assign wb_hit = wb_valid && (st_vec[wb_tag] == ENT_WAIT);
  assign br_hit = br_valid && (st_vec[br_tag] == ENT_BRWAIT);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    ent_state_e st_r;
    logic       mp_r;
    logic       is_head, is_tail, is_wb, is_br;

    assign is_head = (head   == IDX_W'(i));
    assign is_tail = (tail   == IDX_W'(i));
    assign is_wb   = (wb_tag == IDX_W'(i));
    assign is_br   = (br_tag == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst || flush_fire) begin
        st_r <= ENT_FREE;
        mp_r <= 1'b0;
      end else if (retire_fire && is_head) begin
        st_r <= ENT_FREE;
        mp_r <= 1'b0;
      end else if (alloc_fire && is_tail) begin
        st_r <= alloc_is_branch ? ENT_BRWAIT : ENT_WAIT;
        mp_r <= 1'b0;
      end else if (wb_hit && is_wb) begin
        st_r <= ENT_DONE;
      end else if (br_hit && is_br) begin
        st_r <= ENT_DONE;
        mp_r <= br_mispredict;
      end
    end

    assign st_vec[i] = st_r;
    assign mp_vec[i] = mp_r;
  end

  p_wb_free_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && (st_vec[wb_tag] == ENT_FREE) && !(alloc_fire && tail == wb_tag))
      |=> st_vec[$past(wb_tag)] == ENT_FREE);
  p_wb_branch_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && (st_vec[wb_tag] == ENT_BRWAIT) && !flush_fire
       && !(br_valid && br_tag == wb_tag))
      |=> st_vec[$past(wb_tag)] == ENT_BRWAIT);
  p_alloc_into_free_r2: assert property (@(posedge clk) disable iff (rst)
    alloc_fire |-> st_vec[tail] == ENT_FREE);
endmodule

// File: rtl/urob_payload.sv
module urob_payload #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int UOP_W  = 16,
  parameter int ADDR_W = 32,
  parameter int AREG_W = 6
) (
  input  logic              clk,
  input  logic              alloc_fire,
  input  logic [IDX_W-1:0]  tail,
  input  logic [UOP_W-1:0]  in_uop,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [AREG_W-1:0] in_areg,
  input  logic [IDX_W-1:0]  head,
  output logic [UOP_W-1:0]  out_uop,
  output logic [ADDR_W-1:0] out_addr,
  output logic [AREG_W-1:0] out_areg
);
  logic [UOP_W-1:0]  uop_mem  [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [AREG_W-1:0] areg_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      uop_mem[tail]  <= in_uop;
      addr_mem[tail] <= in_addr;
      areg_mem[tail] <= in_areg;
    end
  end

  assign out_uop  = uop_mem[head];
  assign out_addr = addr_mem[head];
  assign out_areg = areg_mem[head];
endmodule

// File: rtl/uop_reorder_buf.sv
module uop_reorder_buf
  import urob_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int UOP_W  = 16,
  parameter int ADDR_W = 32,
  parameter int AREG_W = 6,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic              alloc_is_branch,
  input  logic [UOP_W-1:0]  alloc_uop,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [AREG_W-1:0] alloc_alias,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_tag,
  input  logic              br_valid,
  input  logic [IDX_W-1:0]  br_tag,
  input  logic              br_mispredict,
  output logic              ret_valid,
  output logic              ret_flush,
  output logic [IDX_W-1:0]  ret_tag,
  output logic [UOP_W-1:0]  ret_uop,
  output logic [ADDR_W-1:0] ret_addr,
  output logic [AREG_W-1:0] ret_alias,
  output logic [CNT_W-1:0]  occupancy
);
  logic [IDX_W-1:0]      head, tail;
  logic                  full;
  logic [DEPTH-1:0][1:0] st_vec;
  logic [DEPTH-1:0]      mp_vec;
  // named internal events
  logic alloc_fire, retire_fire, flush_fire, wb_hit, br_hit;

  assign retire_fire = (st_vec[head] == ENT_DONE);
  assign flush_fire  = retire_fire && mp_vec[head];
  assign alloc_ready = !full && !flush_fire;
  assign alloc_fire  = alloc_valid && alloc_ready;

  urob_ptrs #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_ptrs (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .retire_fire(retire_fire),
    .flush_fire(flush_fire), .head(head), .tail(tail), .count(occupancy), .full(full)
  );

  urob_state #(.DEPTH(DEPTH), .IDX_W(IDX_W)) i_state (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .alloc_is_branch(alloc_is_branch),
    .tail(tail), .head(head), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .br_valid(br_valid), .br_tag(br_tag), .br_mispredict(br_mispredict),
    .retire_fire(retire_fire), .flush_fire(flush_fire),
    .st_vec(st_vec), .mp_vec(mp_vec), .wb_hit(wb_hit), .br_hit(br_hit)
  );

  urob_payload #(.DEPTH(DEPTH), .IDX_W(IDX_W), .UOP_W(UOP_W), .ADDR_W(ADDR_W),
                 .AREG_W(AREG_W)) i_payload (
    .clk(clk), .alloc_fire(alloc_fire), .tail(tail), .in_uop(alloc_uop),
    .in_addr(alloc_addr), .in_areg(alloc_alias), .head(head),
    .out_uop(ret_uop), .out_addr(ret_addr), .out_areg(ret_alias)
  );

  assign alloc_tag = tail;
  assign ret_valid = retire_fire;
  assign ret_flush = flush_fire;
  assign ret_tag   = head;

  p_flush_frees_all_r8: assert property (@(posedge clk) disable iff (rst)
    flush_fire |=> st_vec == '0);
  p_flush_blocks_alloc_r8: assert property (@(posedge clk) disable iff (rst)
    flush_fire |-> !alloc_fire);
  p_empty_no_retire_r5: assert property (@(posedge clk) disable iff (rst)
    (occupancy == '0) |-> !ret_valid);
  p_hit_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    (wb_hit && br_hit) |-> (wb_tag != br_tag));
endmodule

// File: tb/test_uop_reorder_buf.sv
`timescale 1ns/1ps
module test_uop_reorder_buf;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        alloc_valid, alloc_is_branch;
  logic [15:0] alloc_uop;
  logic [31:0] alloc_addr;
  logic [5:0]  alloc_alias;
  logic        alloc_ready;
  logic [3:0]  alloc_tag;
  logic        wb_valid;
  logic [3:0]  wb_tag;
  logic        br_valid;
  logic [3:0]  br_tag;
  logic        br_mispredict;
  logic        ret_valid, ret_flush;
  logic [3:0]  ret_tag;
  logic [15:0] ret_uop;
  logic [31:0] ret_addr;
  logic [5:0]  ret_alias;
  logic [4:0]  occupancy;

  always #2.5 clk = ~clk;

  uop_reorder_buf i_uop_reorder_buf (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_is_branch(alloc_is_branch),
    .alloc_uop(alloc_uop), .alloc_addr(alloc_addr), .alloc_alias(alloc_alias),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .br_valid(br_valid), .br_tag(br_tag), .br_mispredict(br_mispredict),
    .ret_valid(ret_valid), .ret_flush(ret_flush), .ret_tag(ret_tag), .ret_uop(ret_uop),
    .ret_addr(ret_addr), .ret_alias(ret_alias), .occupancy(occupancy)
  );

  typedef struct {
    int          tag;
    logic [15:0] uop;
    logic [31:0] addr;
    logic [5:0]  areg;
    bit          br;
    bit          done;
    bit          mis;
  } slot_t;

  slot_t q[$];
  int    m_tail;
  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit m_ret();   return q.size() > 0 && q[0].done; endfunction
  function automatic bit m_flush(); return m_ret() && q[0].mis; endfunction
  function automatic bit m_ready(); return q.size() < N && !m_flush(); endfunction

  task automatic compare_all();
    check("R10 occupancy", occupancy, q.size());
    check("R3 alloc_ready", alloc_ready, m_ready());
    check("R2 alloc_tag", alloc_tag, m_tail);
    check("R5 ret_valid", ret_valid, m_ret());
    if (m_ret() && ret_valid) begin
      check("R8 ret_flush", ret_flush, q[0].mis);
      check("R4 ret_tag", ret_tag, q[0].tag);
      check("R4 ret_uop", ret_uop, q[0].uop);
      check("R4 ret_addr", ret_addr, q[0].addr);
      check("R4 ret_alias", ret_alias, q[0].areg);
    end
  endtask

  task automatic model_update();
    bit ret = m_ret();
    bit fl  = m_flush();
    bit rdy = m_ready();
    foreach (q[k]) begin
      if (wb_valid && q[k].tag == int'(wb_tag) && !q[k].br && !q[k].done) q[k].done = 1;
      if (br_valid && q[k].tag == int'(br_tag) && q[k].br && !q[k].done) begin
        q[k].done = 1;
        q[k].mis  = br_mispredict;
      end
    end
    if (ret) begin
      if (fl) begin
        m_tail = (q[0].tag + 1) % N;
        q.delete();
      end else begin
        void'(q.pop_front());
      end
    end
    if (alloc_valid && rdy) begin
      q.push_back('{tag: m_tail, uop: alloc_uop, addr: alloc_addr, areg: alloc_alias,
                    br: alloc_is_branch, done: 0, mis: 0});
      m_tail = (m_tail + 1) % N;
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; alloc_is_branch = 0; alloc_uop = '0; alloc_addr = '0; alloc_alias = '0;
    wb_valid = 0; wb_tag = '0; br_valid = 0; br_tag = '0; br_mispredict = 0;
  endtask

  // inputs are set at the falling edge; outputs compared 1 ns later
  task automatic cycle();
    #1;
    compare_all();
    @(posedge clk);
    model_update();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic do_alloc(bit br, int salt);
    alloc_valid = 1; alloc_is_branch = br;
    alloc_uop = 16'(16'h1200 + salt); alloc_addr = 32'(32'hA000_0000 + salt * 4);
    alloc_alias = 6'(salt + 3);
    cycle();
  endtask

  task automatic do_wb(int t);
    wb_valid = 1; wb_tag = 4'(t); cycle();
  endtask

  task automatic do_br(int t, bit mis);
    br_valid = 1; br_tag = 4'(t); br_mispredict = mis; cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    q.delete(); m_tail = 0;
    #1;
    // R1 reset state
    check("R1 occupancy", occupancy, 0);
    check("R1 alloc_ready", alloc_ready, 1);
    check("R1 alloc_tag", alloc_tag, 0);
    check("R1 ret_valid", ret_valid, 0);
    @(negedge clk);

    // out-of-order completion, in-order retirement
    for (int i = 0; i < 4; i++) do_alloc(0, i);
    check("R2 four allocated", occupancy, 4);
    check("R2 next tag", alloc_tag, 4);
    do_wb(2);
    check("R5 younger done, head waiting", ret_valid, 0);
    do_wb(0);
    check("R4 head retires first", ret_valid, 1);
    check("R4 head tag", ret_tag, 0);
    cycle();
    check("R5 slot1 not done", ret_valid, 0);
    check("R10 after one retire", occupancy, 3);
    do_wb(3);
    do_wb(1);
    check("R4 slot1 retires", ret_tag, 1);
    repeat (4) cycle();
    check("R10 drained", occupancy, 0);

    // full buffer
    for (int i = 0; i < N; i++) do_alloc(0, 20 + i);
    check("R3 full occupancy", occupancy, 16);
    check("R3 full not ready", alloc_ready, 0);
    do_alloc(0, 99);
    check("R3 alloc while full ignored", occupancy, 16);
    for (int k = 0; k < N; k++) do_wb((4 + 15 - k) % N);
    check("R4 oldest retires", ret_tag, 4);
    cycle();
    check("R10 one retire", occupancy, 15);
    do_alloc(0, 50);
    check("R10 alloc with retire", occupancy, 15);
    do_wb(4);
    repeat (20) cycle();
    check("R10 drained again", occupancy, 0);

    // correctly predicted branch
    do_alloc(0, 60);
    do_alloc(1, 61);
    do_alloc(0, 62);
    do_wb(7);
    do_wb(5);
    do_wb(6);
    check("R6 branch ignores completion", ret_valid, 0);
    cycle();
    check("R6 branch still waiting", ret_valid, 0);
    check("R5 done slot held back", occupancy, 2);
    do_br(6, 0);
    check("R7 branch retires", ret_valid, 1);
    check("R7 no flush", ret_flush, 0);
    check("R7 branch tag", ret_tag, 6);
    cycle();
    check("R7 younger kept", ret_tag, 7);
    cycle();
    check("R7 drained", occupancy, 0);

    // mispredicted branch
    do_alloc(1, 70);
    do_alloc(0, 71);
    do_alloc(0, 72);
    do_wb(9);
    do_wb(10);
    do_br(8, 1);
    check("R8 flush raised", ret_flush, 1);
    check("R8 flush tag", ret_tag, 8);
    check("R8 no alloc at flush", alloc_ready, 0);
    cycle();
    check("R8 emptied", occupancy, 0);
    check("R8 tail after branch", alloc_tag, 9);
    do_wb(9);
    check("R9 stale completion", ret_valid, 0);
    check("R9 stale occupancy", occupancy, 0);
    do_alloc(0, 73);
    check("R9 reused slot waits", ret_valid, 0);
    do_wb(9);
    check("R9 own completion", ret_valid, 1);
    repeat (3) cycle();

    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      alloc_valid     = ($urandom % 3) != 0;
      alloc_is_branch = ($urandom % 5) == 0;
      alloc_uop       = 16'($urandom);
      alloc_addr      = $urandom;
      alloc_alias     = 6'($urandom);
      wb_valid        = ($urandom % 2) == 0;
      if (q.size() > 0 && ($urandom % 4) != 0) wb_tag = 4'(q[$urandom % q.size()].tag);
      else wb_tag = 4'($urandom);
      begin
        int cand[$];
        foreach (q[k]) if (q[k].br && !q[k].done) cand.push_back(q[k].tag);
        br_valid = (cand.size() > 0) && (($urandom % 3) == 0);
        br_tag   = (cand.size() > 0) ? 4'(cand[$urandom % cand.size()]) : 4'($urandom);
        br_mispredict = ($urandom % 6) == 0;
      end
      cycle();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule